// File: doc/BRIEF.md
# Reclocked Stream Lock Qualifier and Output Mute

This block decides whether a clock-and-data recovery loop is genuinely locked to its incoming serial stream, and it gates the retimed data that leaves the receiver. It watches the recovered bit stream, qualified by a valid strobe, for bit transitions and for isolated single bits. It also takes a phase-lock flag from the loop and a carrier-present flag from the front end. From these it drives a lock indication. It also drives a data output that either follows the stream or freezes at a static level.

A loop that has locked on a harmonic samples every bit twice. Its stream still toggles, but it never contains a lone bit between two opposite neighbours. The block therefore demands such an isolated bit inside a time window, in addition to plain transition activity and the loop's own phase flag. All windows are counted in cycles of the single block clock. A short interruption is bridged, so brief source switches do not disturb the output.

Top module: `rx_lock_mute`

## Requirements
- R1: While reset is active and on the first cycle after it, `lock_o` is 0 and `data_o` is 0.
- R2: `lock_o` rises only after the three conditions (data present, `phase_lock_i` high, not harmonic-locked) have held together for ACQ_WIN consecutive cycles. It is never high earlier than ACQ_WIN cycles after they first hold.
- R3: Data is present while a transition has been seen within the last DATA_WIN cycles. A transition is a valid bit that differs from the previous valid bit. When valid strobes stop for longer than DATA_WIN + GLITCH_WIN cycles, `lock_o` falls.
- R4: The loop counts as not harmonic-locked while a 101 or 010 sequence of three consecutive valid bits has occurred within the last HARM_WIN cycles. A doubled stream such as 110011001100 never satisfies this, so `lock_o` stays low under it, or falls within HARM_WIN + GLITCH_WIN cycles.
- R5: Once high, `lock_o` falls only after the combined condition has been false for GLITCH_WIN consecutive cycles. A shorter loss of `phase_lock_i`, or a strobe gap shorter than DATA_WIN cycles, leaves `lock_o` high and the data path open.
- R6: While `lock_o` is low, `data_o` holds its last value regardless of the incoming bits.
- R7: While `lock_o` is high and carrier muting is inactive, each valid bit appears on `data_o` on the clock edge that samples it. Without a valid strobe, `data_o` holds.
- R8: When `carrier_ok_i` is 0 and `cd_mute_off_i` is 0, `data_o` holds its value. `lock_o` is unaffected by the carrier flag.
- R9: With `cd_mute_off_i` at 1, a low `carrier_ok_i` does not mute `data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld_i | input | 1 | Strobe marking a valid recovered bit |
| bit_i | input | 1 | Recovered bit |
| phase_lock_i | input | 1 | Phase-lock flag from the loop |
| carrier_ok_i | input | 1 | Carrier-present flag, 1 = carrier seen |
| cd_mute_off_i | input | 1 | 1 disables carrier-based muting |
| lock_o | output | 1 | Qualified lock indication |
| data_o | output | 1 | Gated retimed data |

## Verification
A stuck or mis-counting window counter shows up at `lock_o` as a lock that comes too early, never comes, or fails to drop within DATA_WIN, HARM_WIN or GLITCH_WIN cycles of the stimulus that should end it. The bench therefore probes each window a few cycles inside and a few cycles beyond its limit. A wrong history register in the pattern detector lets a doubled stream hold lock. That is visible once the harmonic window has run out. A gating fault appears on `data_o` on the very next edge, as a bit that passes while muted or a frozen level while open.

// File: rtl/rx_lock_mute_pkg.sv
package rx_lock_mute_pkg;

    typedef enum logic {
        LK_HUNT   = 1'b0,
        LK_LOCKED = 1'b1
    } lock_state_e;

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/rx_edge_tracker.sv
module rx_edge_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    input  logic bit_i,
    output logic trans_o,
    output logic iso_o
);
    typedef struct packed {
        logic [1:0] hist;
        logic [1:0] fill;
    } trk_t;

    trk_t st_d, st_q;
    logic trans_c, iso_c;

    always_comb begin
        st_d    = st_q;
        trans_c = vld_i && (st_q.fill != 2'd0) && (bit_i != st_q.hist[0]);
        iso_c   = trans_c && (st_q.fill == 2'd2) && (st_q.hist[0] != st_q.hist[1]);
        if (vld_i) begin
            st_d.hist = {st_q.hist[0], bit_i};
            if (st_q.fill != 2'd2) begin
                st_d.fill = st_q.fill + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trans_o = trans_c;
    assign iso_o   = iso_c;

    // R4: an isolated bit needs a strobe and two earlier strobed bits
    a_r4_iso_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
        iso_o |-> (vld_i && st_q.fill == 2'd2));
endmodule

// File: rtl/rx_window_monitor.sv
module rx_window_monitor #(
    parameter int WIN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    output logic ok_o
);
    import rx_lock_mute_pkg::*;

    localparam int CW = cnt_width(WIN);
    localparam logic [CW-1:0] LIMIT = CW'(WIN);

    typedef struct packed {
        logic [CW-1:0] age;
        logic          seen;
    } win_t;

    win_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (event_i) begin
            st_d.age  = '0;
            st_d.seen = 1'b1;
        end else if (st_q.age < LIMIT) begin
            st_d.age = st_q.age + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ok_o = st_q.seen && (st_q.age < LIMIT);

    // R3 / R4: a qualifying event opens the window on the next cycle
    a_r3_event_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
        event_i |=> ok_o);
endmodule

// File: rtl/rx_lock_fsm.sv
module rx_lock_fsm #(
    parameter int ACQ_WIN    = 16,
    parameter int GLITCH_WIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    output logic lock_o
);
    import rx_lock_mute_pkg::*;

    localparam int AW = cnt_width(ACQ_WIN);
    localparam int GW = cnt_width(GLITCH_WIN);
    localparam logic [AW-1:0] ACQ_LAST = AW'(ACQ_WIN - 1);
    localparam logic [GW-1:0] DRP_LAST = GW'(GLITCH_WIN - 1);

    typedef struct packed {
        lock_state_e   state;
        logic [AW-1:0] acq;
        logic [GW-1:0] drp;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            LK_HUNT: begin
                st_d.drp = '0;
                if (!cond_i) begin
                    st_d.acq = '0;
                end else if (st_q.acq == ACQ_LAST) begin
                    st_d.acq   = '0;
                    st_d.state = LK_LOCKED;
                end else begin
                    st_d.acq = st_q.acq + 1'b1;
                end
            end
            LK_LOCKED: begin
                st_d.acq = '0;
                if (cond_i) begin
                    st_d.drp = '0;
                end else if (st_q.drp == DRP_LAST) begin
                    st_d.drp   = '0;
                    st_d.state = LK_HUNT;
                end else begin
                    st_d.drp = st_q.drp + 1'b1;
                end
            end
            default: st_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: LK_HUNT, acq: '0, drp: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_o = (st_q.state == LK_LOCKED);

    // R2: lock only rises after a cycle in which all conditions held
    a_r2_rise_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(cond_i));
    // R5: lock only falls after a cycle in which the conditions failed
    a_r5_fall_needs_loss: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> !$past(cond_i));
endmodule

// File: rtl/rx_mute_gate.sv
module rx_mute_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pass_i,
    input  logic vld_i,
    input  logic bit_i,
    output logic data_o
);
    typedef struct packed {
        logic dat;
    } gate_t;

    gate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pass_i && vld_i) begin
            st_d.dat = bit_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.dat;

    // R6 / R8: a closed gate freezes the output
    a_r6_mute_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_i |=> $stable(data_o));
    // R7: an open gate forwards the strobed bit on the next edge
    a_r7_pass_forwards: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_i && vld_i) |=> (data_o == $past(bit_i)));
endmodule

// File: rtl/rx_lock_mute.sv
module rx_lock_mute #(
    parameter int DATA_WIN   = 250,
    parameter int HARM_WIN   = 37500,
    parameter int GLITCH_WIN = 125,
    parameter int ACQ_WIN    = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld_i,
    input  logic bit_i,
    input  logic phase_lock_i,
    input  logic carrier_ok_i,
    input  logic cd_mute_off_i,
    output logic lock_o,
    output logic data_o
);
    logic trans_ev, iso_ev;
    logic data_ok, harm_ok;
    logic all_ok, lock_w, carrier_mute, pass_w;

    rx_edge_tracker u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (bit_vld_i),
        .bit_i   (bit_i),
        .trans_o (trans_ev),
        .iso_o   (iso_ev)
    );

    rx_window_monitor #(.WIN(DATA_WIN)) u_act_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (trans_ev),
        .ok_o    (data_ok)
    );

    rx_window_monitor #(.WIN(HARM_WIN)) u_harm_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (iso_ev),
        .ok_o    (harm_ok)
    );

    assign all_ok = data_ok && harm_ok && phase_lock_i;

    rx_lock_fsm #(.ACQ_WIN(ACQ_WIN), .GLITCH_WIN(GLITCH_WIN)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (all_ok),
        .lock_o (lock_w)
    );

    assign carrier_mute = !carrier_ok_i && !cd_mute_off_i;
    assign pass_w       = lock_w && !carrier_mute;

    rx_mute_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .pass_i (pass_w),
        .vld_i  (bit_vld_i),
        .bit_i  (bit_i),
        .data_o (data_o)
    );

    assign lock_o = lock_w;

    // R8: with carrier muting active the output never changes
    a_r8_carrier_mutes: assert property (@(posedge clk) disable iff (!rst_n)
        (!carrier_ok_i && !cd_mute_off_i) |=> $stable(data_o));
    // R6: output frozen whenever lock is low
    a_r6_unlocked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_o |=> $stable(data_o));
endmodule

// File: tb/rx_lock_mute_tb.sv
module rx_lock_mute_tb;
    localparam int DW = 16;
    localparam int HW = 48;
    localparam int GW = 6;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_vld_i = 1'b0, bit_i = 1'b0;
    logic phase_lock_i = 1'b0, carrier_ok_i = 1'b1, cd_mute_off_i = 1'b0;
    logic lock_o, data_o;

    int checks = 0;
    int failures = 0;
    int run = 0;
    logic last_bit = 1'b0;

    always #2 clk = ~clk;

    rx_lock_mute #(.DATA_WIN(DW), .HARM_WIN(HW), .GLITCH_WIN(GW), .ACQ_WIN(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
        .phase_lock_i(phase_lock_i), .carrier_ok_i(carrier_ok_i),
        .cd_mute_off_i(cd_mute_off_i), .lock_o(lock_o), .data_o(data_o));

    // doubled stream 1100 1100: transitions but never an isolated bit
    function automatic logic harm_bit(input int i);
        return ((i / 2) % 2) == 0;
    endfunction

    // expected output of the gate for one cycle
    function automatic logic exp_out(input logic open, input logic vld,
                                     input logic b, input logic prev);
        return (open && vld) ? b : prev;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic v, input logic b);
        bit_vld_i = v;
        bit_i = b;
        @(posedge clk);
        #1;
    endtask

    function automatic logic rnd_bit();
        logic b;
        b = 1'($urandom % 2);
        if (run >= 3 && b == last_bit) b = ~b;
        return b;
    endfunction

    task automatic rnd_tick(input logic v);
        logic b;
        b = rnd_bit();
        if (v) begin
            run = (b == last_bit) ? run + 1 : 0;
            last_bit = b;
        end
        tick(v, b);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic bad;
        logic held;
        logic exp;
        void'($urandom(32'd1234));

        // R1 reset state
        repeat (4) tick(1'b0, 1'b1);
        chk(lock_o == 1'b0, "R1 lock in reset", lock_o, 0);
        chk(data_o == 1'b0, "R1 data in reset", data_o, 0);
        rst_n = 1'b1;
        tick(1'b0, 1'b0);
        chk(lock_o == 1'b0 && data_o == 1'b0, "R1 after release", {lock_o, data_o}, 0);

        // R4 harmonic stream never locks, R6 output stays muted
        phase_lock_i = 1'b1;
        bad = 1'b0;
        for (int i = 0; i < 120; i++) begin
            tick(1'b1, harm_bit(i));
            if (lock_o || data_o) bad = 1'b1;
        end
        chk(!bad, "R4 doubled stream keeps lock low", bad, 0);
        chk(data_o == 1'b0, "R6 muted output held", data_o, 0);

        // R2 acquisition not early, then lock
        bad = 1'b0;
        for (int i = 0; i < AW - 1; i++) begin
            rnd_tick(1'b1);
            if (lock_o) bad = 1'b1;
        end
        chk(!bad, "R2 no early lock", bad, 0);
        for (int i = 0; i < 60; i++) rnd_tick(1'b1);
        chk(lock_o == 1'b1, "R2 lock acquired", lock_o, 1);

        // R7 random strobes pass through
        bad = 1'b0;
        exp = data_o;
        for (int i = 0; i < 300; i++) begin
            logic v;
            logic b;
            v = ($urandom % 4) != 0;
            b = rnd_bit();
            if (v) begin
                run = (b == last_bit) ? run + 1 : 0;
                last_bit = b;
            end
            tick(v, b);
            exp = exp_out(1'b1, v, b, exp);
            if (data_o !== exp || !lock_o) bad = 1'b1;
        end
        chk(!bad, "R7 data follows strobed bits", data_o, exp);

        // R5 short strobe gap keeps lock and keeps output open
        held = data_o;
        bad = 1'b0;
        for (int i = 0; i < 10; i++) begin
            tick(1'b0, ~held);
            if (!lock_o || data_o != held) bad = 1'b1;
        end
        chk(!bad, "R5 short gap bridged", lock_o, 1);
        rnd_tick(1'b1);
        chk(data_o == last_bit, "R5 output open after gap", data_o, last_bit);
        for (int i = 0; i < 20; i++) rnd_tick(1'b1);

        // R5 short phase-lock blip
        bad = 1'b0;
        phase_lock_i = 1'b0;
        for (int i = 0; i < GW - 1; i++) begin
            rnd_tick(1'b1);
            if (!lock_o) bad = 1'b1;
        end
        phase_lock_i = 1'b1;
        for (int i = 0; i < 10; i++) begin
            rnd_tick(1'b1);
            if (!lock_o) bad = 1'b1;
        end
        chk(!bad, "R5 short blip keeps lock", lock_o, 1);

        // R8 carrier loss mutes, lock unaffected
        carrier_ok_i = 1'b0;
        held = data_o;
        bad = 1'b0;
        for (int i = 0; i < 30; i++) begin
            rnd_tick(1'b1);
            if (data_o != held) bad = 1'b1;
        end
        chk(!bad, "R8 carrier loss holds data", data_o, held);
        chk(lock_o == 1'b1, "R8 lock unaffected by carrier", lock_o, 1);

        // R9 mute disable
        cd_mute_off_i = 1'b1;
        bad = 1'b0;
        for (int i = 0; i < 30; i++) begin
            rnd_tick(1'b1);
            if (data_o != last_bit) bad = 1'b1;
        end
        chk(!bad, "R9 disable lets data pass", data_o, last_bit);
        carrier_ok_i = 1'b1;
        cd_mute_off_i = 1'b0;

        // R4 harmonic slip while locked
        for (int i = 0; i < 20; i++) tick(1'b1, harm_bit(i));
        chk(lock_o == 1'b1, "R4 lock held inside harmonic window", lock_o, 1);
        for (int i = 20; i < 120; i++) tick(1'b1, harm_bit(i));
        chk(lock_o == 1'b0, "R4 harmonic lock detected", lock_o, 0);
        for (int i = 0; i < 80; i++) rnd_tick(1'b1);
        chk(lock_o == 1'b1, "R2 relock after harmonic", lock_o, 1);

        // R5 sustained phase loss drops lock after GLITCH_WIN
        phase_lock_i = 1'b0;
        for (int i = 0; i < GW - 2; i++) rnd_tick(1'b1);
        chk(lock_o == 1'b1, "R5 lock before glitch limit", lock_o, 1);
        for (int i = 0; i < 3; i++) rnd_tick(1'b1);
        chk(lock_o == 1'b0, "R5 lock dropped after glitch limit", lock_o, 0);
        held = data_o;
        bad = 1'b0;
        for (int i = 0; i < 25; i++) begin
            rnd_tick(1'b1);
            if (data_o != held) bad = 1'b1;
        end
        chk(!bad, "R6 unlocked output frozen", data_o, held);

        // R3 long gap drops lock
        phase_lock_i = 1'b1;
        for (int i = 0; i < 80; i++) rnd_tick(1'b1);
        chk(lock_o == 1'b1, "R3 relock before gap", lock_o, 1);
        for (int i = 0; i < DW + GW + 10; i++) tick(1'b0, 1'b0);
        chk(lock_o == 1'b0, "R3 long gap clears lock", lock_o, 0);
        held = data_o;
        bad = 1'b0;
        for (int i = 0; i < 8; i++) begin
            rnd_tick(1'b1);
            if (data_o != held || lock_o) bad = 1'b1;
        end
        chk(!bad, "R6 muted while reacquiring", data_o, held);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule